// File: doc/BRIEF.md
# Comparator Edge Event Interrupt Logic

This block receives the digital outputs of three analog comparators and turns selected transitions on them into sticky per-channel interrupt flags. It also combines those flags into a single interrupt request. Each comparator output is asynchronous to the block clock, so it first passes through a synchronizer. A per-channel invert bit can then flip it. The result is shown in a readable level field, and the per-channel event selector examines it for transitions.

Software works through a small register port. This port has a write strobe, an address, write data and combinational read data. Each channel has its own configuration word, which holds the event selector and the invert bit. Three more words hold the live levels, the flags and the enables. A flag stays set until software writes 0 to it. Software can also write 1 to a flag to raise a simulated interrupt. The request goes out only when the channel enable, the group enable and the global enable are all set.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset every readable word (addresses 0 to 5, and unused addresses 6 and 7) reads 0 while all comparator inputs are low, and irq_o is low. The register map is as follows:
  - Addresses 0, 1 and 2 are the configuration words of channels 0, 1 and 2.
  - Address 3 is the level field and is read-only.
  - Address 4 holds the flags, with bit n for channel n.
  - Address 5 holds the enables: channel enables in bits 2:0, the group enable in bit 6 and the global enable in bit 7.
- R2: Event code 00 (configuration bits 1:0) never sets a flag, whatever the input does.
- R3: Event code 01 sets the flag on a low-to-high change of the polarity-adjusted level. Take a comparator change that is first sampled at clock edge k. It shows up in the level field after edge k+1 and in the flag after edge k+2.
- R4: Event code 10 sets the flag on a high-to-low change of the polarity-adjusted level.
- R5: Event code 11 sets the flag on any change of the polarity-adjusted level.
- R6: The invert bit (configuration bit 2) inverts both the level field and the edge direction. Toggling the invert bit while the input is steady sets no flag.
- R7: A flag stays set until software writes 0 to its bit. Writing 1 sets the flag.
- R8: If a hardware event and a software write of 0 hit the same flag in the same cycle, the flag ends set.
- R9: irq_o is high only when both the global and group enables are set and at least one channel has both its flag and its enable set. Flags are set on events regardless of any enable.
- R10: A level that is present when reset is released produces no event, even if the channel is set to any-change before its first synchronized sample arrives.
- R11: The level field at address 3 shows each channel's synchronized, polarity-adjusted comparator output in bit n. Writes to this address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | NCH | Asynchronous comparator outputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Register read data for addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The event logic is tried with rising and falling input steps under every event code and both invert settings. This separates a detector that ignores the invert bit from one that swaps direction correctly, and any-change from single-edge detection. Directed sequences then cover four cases:
- Toggling the invert bit on a steady input, which would show a spurious event.
- A high level held across reset release, which exposes an unprimed history register.
- A clear write landing in the exact cycle of an event, which shows which side wins.
- Enable combinations that each drop one of the three gating levels.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    EVT_NONE = 2'b00,
    EVT_RISE = 2'b01,
    EVT_FALL = 2'b10,
    EVT_ANY  = 2'b11
  } evt_sel_e;

  typedef struct packed {
    logic     inv;
    evt_sel_e sel;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic valid_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      fill_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      fill_q  <= {fill_q[STAGES-2:0], 1'b1};
    end
  end

  assign q_o     = chain_q[STAGES-1];
  assign valid_o = fill_q[STAGES-1];

endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sync_i,
  input  logic    valid_i,
  input  ch_cfg_t cfg_i,
  output logic    evt_o,
  output logic    level_o
);

  logic prev_q;
  logic armed_q;
  logic rise_raw, fall_raw, rise_eff, fall_eff, hit;

  // history holds the raw sample, so an invert toggle never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (valid_i) begin
      prev_q  <= sync_i;
      armed_q <= 1'b1;
    end
  end

  assign rise_raw = sync_i & ~prev_q;
  assign fall_raw = ~sync_i & prev_q;
  assign rise_eff = cfg_i.inv ? fall_raw : rise_raw;
  assign fall_eff = cfg_i.inv ? rise_raw : fall_raw;

  always_comb begin
    unique case (cfg_i.sel)
      EVT_NONE: hit = 1'b0;
      EVT_RISE: hit = rise_eff;
      EVT_FALL: hit = fall_eff;
      EVT_ANY:  hit = rise_raw | fall_raw;
      default:  hit = 1'b0;
    endcase
  end

  assign evt_o   = armed_q & hit;
  assign level_o = sync_i ^ cfg_i.inv;

  a_r10_quiet_before_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !evt_o);

endmodule

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] evt_i,
  input  logic           sw_wr_i,
  input  logic [NCH-1:0] sw_val_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic           grp_en_i,
  input  logic           glb_en_i,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o
);

  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] flag_d;

  // hardware event dominates a software clear in the same cycle
  assign flag_d = (sw_wr_i ? sw_val_i : flag_q) | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = glb_en_i & grp_en_i & |(flag_q & ch_en_i);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sw_wr_i && flag_q[g]) |=> flag_q[g]);
    a_r7_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_wr_i && !sw_val_i[g] && !evt_i[g]) |=> !flag_q[g]);
    a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_q[g]);
  end

endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
  import cmp_evt_pkg::*;
#(
  parameter  int unsigned NCH         = 3,
  parameter  int unsigned DW          = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW          = $clog2(NCH + 3)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cmp_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           irq_o
);

  localparam logic [AW-1:0] LVL_ADDR  = AW'(NCH);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(NCH + 1);
  localparam logic [AW-1:0] EN_ADDR   = AW'(NCH + 2);
  localparam int unsigned   GRP_BIT   = DW - 2;
  localparam int unsigned   GLB_BIT   = DW - 1;

  ch_cfg_t        cfg_q [NCH];
  logic [NCH-1:0] ch_en_q;
  logic           grp_en_q, glb_en_q;
  logic [NCH-1:0] sync_w, valid_w, evt_w, level_w, flag_w;
  logic           flag_wr;
  logic           unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign flag_wr      = wr_en_i && (addr_i == FLAG_ADDR);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .d_i     (cmp_i[g]),
      .q_o     (sync_w[g]),
      .valid_o (valid_w[g])
    );

    cmp_edge_det u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync_w[g]),
      .valid_i (valid_w[g]),
      .cfg_i   (cfg_q[g]),
      .evt_o   (evt_w[g]),
      .level_o (level_w[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cfg_q[g] <= '0;
      else if (wr_en_i && (addr_i == AW'(g)))     cfg_q[g] <= ch_cfg_t'(wdata_i[CFG_W-1:0]);
    end

    a_r2_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[g].sel == EVT_NONE) |-> !evt_w[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_en_q  <= '0;
      grp_en_q <= 1'b0;
      glb_en_q <= 1'b0;
    end else if (wr_en_i && (addr_i == EN_ADDR)) begin
      ch_en_q  <= wdata_i[NCH-1:0];
      grp_en_q <= wdata_i[GRP_BIT];
      glb_en_q <= wdata_i[GLB_BIT];
    end
  end

  cmp_flag_ctrl #(.NCH(NCH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_w),
    .sw_wr_i  (flag_wr),
    .sw_val_i (wdata_i[NCH-1:0]),
    .ch_en_i  (ch_en_q),
    .grp_en_i (grp_en_q),
    .glb_en_i (glb_en_q),
    .flag_o   (flag_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(i)) rdata_o[CFG_W-1:0] = cfg_q[i];
    end
    if (addr_i == LVL_ADDR)  rdata_o[NCH-1:0] = level_w;
    if (addr_i == FLAG_ADDR) rdata_o[NCH-1:0] = flag_w;
    if (addr_i == EN_ADDR) begin
      rdata_o[NCH-1:0] = ch_en_q;
      rdata_o[GRP_BIT] = grp_en_q;
      rdata_o[GLB_BIT] = glb_en_q;
    end
  end

  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_q || !grp_en_q) |-> !irq_o);
  a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_w != '0));

endmodule

// File: tb/cmp_evt_irq_bench.sv
module cmp_evt_irq_bench;

  localparam int NCH = 3;
  localparam int DW  = 8;
  localparam int AW  = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NCH-1:0] cmp_i = '0;
  logic           wr_en_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic [DW-1:0]  wdata_i = '0;
  logic [DW-1:0]  rdata_o;
  logic           irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  cmp_evt_irq u_cmp_evt_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {sel[1:0], inv, from, to, exp_flag, exp_level}
  localparam logic [6:0] VEC [16] = '{
    7'b00_0_0_1_0_1, 7'b00_0_1_0_0_0, 7'b00_1_0_1_0_0, 7'b00_1_1_0_0_1,
    7'b01_0_0_1_1_1, 7'b01_0_1_0_0_0, 7'b01_1_0_1_0_0, 7'b01_1_1_0_1_1,
    7'b10_0_0_1_0_1, 7'b10_0_1_0_1_0, 7'b10_1_0_1_1_0, 7'b10_1_1_0_0_1,
    7'b11_0_0_1_1_1, 7'b11_0_1_0_1_0, 7'b11_1_0_1_1_0, 7'b11_1_1_0_1_1
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic cfg_all(input logic [2:0] c);
    for (int i = 0; i < NCH; i++) wr(AW'(i), {5'b0, c});
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    string tag;

    // R1: reset state
    wait_clk(3);
    @(negedge clk_i) rst_ni = 1'b1;
    wait_clk(4);
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), d);
      check("R1", d, 8'h00);
    end
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    // R10: level high across reset release, any-change configured early
    @(negedge clk_i) begin rst_ni = 1'b0; cmp_i = 3'b111; end
    wait_clk(3);
    @(negedge clk_i) rst_ni = 1'b1;
    wr(0, 8'h03);
    wait_clk(6);
    rd(4, d); check("R10 flag", d, 8'h00);
    rd(3, d); check("R11 level", d, 8'h07);

    // vector table: R2..R6
    for (int v = 0; v < 16; v++) begin
      logic [2:0] c;
      c = {VEC[v][4], VEC[v][6:5]};
      cfg_all(c);
      cmp_i = {NCH{VEC[v][3]}};
      wait_clk(6);
      wr(4, 8'h00);
      @(negedge clk_i) cmp_i = {NCH{VEC[v][2]}};
      wait_clk(6);
      case (VEC[v][6:5])
        2'b00:   tag = "R2";
        2'b01:   tag = "R3";
        2'b10:   tag = "R4";
        default: tag = "R5";
      endcase
      rd(4, d); check(tag, d, {5'b0, {NCH{VEC[v][1]}}});
      rd(3, d); check("R6 level", d, {5'b0, {NCH{VEC[v][0]}}});
    end

    // R6: invert toggle on steady input; R11 per-bit levels, write ignored
    cfg_all(3'b011);
    cmp_i = 3'b101;
    wait_clk(6);
    wr(4, 8'h00);
    rd(3, d); check("R11 level", d, 8'h05);
    wr(1, 8'h07);
    wait_clk(6);
    rd(4, d); check("R6 no event", d, 8'h00);
    rd(3, d); check("R6 level", d, 8'h07);
    wr(3, 8'h00);
    rd(3, d); check("R11 ro", d, 8'h07);

    // R7: software set and clear
    cfg_all(3'b000);
    wr(4, 8'h02);
    rd(4, d); check("R7 set", d, 8'h02);
    wait_clk(5);
    rd(4, d); check("R7 sticky", d, 8'h02);
    wr(4, 8'h00);
    rd(4, d); check("R7 clear", d, 8'h00);

    // R3 cycle timing
    cfg_all(3'b000);
    wr(0, 8'h01);
    cmp_i = 3'b000;
    wait_clk(6);
    wr(4, 8'h00);
    @(negedge clk_i) begin cmp_i = 3'b001; addr_i = 3; end
    @(posedge clk_i);
    @(negedge clk_i); #1 check("R3 level k", rdata_o, 8'h00);
    @(posedge clk_i);
    @(negedge clk_i) addr_i = 3; #1 check("R3 level k+1", rdata_o, 8'h01);
    addr_i = 4; #1 check("R3 flag k+1", rdata_o, 8'h00);
    @(posedge clk_i);
    @(negedge clk_i); #1 check("R3 flag k+2", rdata_o, 8'h01);

    // R8: clear collides with event
    wr(0, 8'h03);
    wr(4, 8'h00);
    @(negedge clk_i) cmp_i = 3'b000;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i) begin wr_en_i = 1'b1; addr_i = 4; wdata_i = 8'h00; end
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
    rd(4, d); check("R8 collide", d, 8'h01);

    // R9: enable gating
    cfg_all(3'b000);
    wr(4, 8'h02);
    wr(5, 8'h02); check("R9 ch only", {7'b0, irq_o}, 8'h00);
    wr(5, 8'h42); check("R9 no glb", {7'b0, irq_o}, 8'h00);
    wr(5, 8'h82); check("R9 no grp", {7'b0, irq_o}, 8'h00);
    wr(5, 8'hC2); check("R9 all", {7'b0, irq_o}, 8'h01);
    wr(5, 8'hC1); check("R9 other ch", {7'b0, irq_o}, 8'h00);
    wr(5, 8'h00);
    wr(4, 8'h00);
    wr(2, 8'h01);
    cmp_i = 3'b100;
    wait_clk(5);
    rd(4, d); check("R9 flag no en", d, 8'h04);
    check("R9 masked", {7'b0, irq_o}, 8'h00);
    wr(5, 8'hC4); check("R9 event irq", {7'b0, irq_o}, 8'h01);
    wr(4, 8'h00); check("R9 cleared", {7'b0, irq_o}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule